// File: doc/BRIEF.md
# Masked Port Change Interrupt Detector

This block watches seven port levels and raises a latched interrupt when any port selected by a mask moves away from a stored baseline. Software arms detection with a configuration write that has the enable bit set. That write captures the current synchronized port levels as the baseline and pulls the interrupt low.

While the block is armed, any unmasked difference sets the interrupt and disarms detection. The interrupt then stays high until the mask register is read or written. Detection does not come back after the clear. Software must issue another configuration write with the enable bit set to arm it again.

The port levels pass through a synchronizer before the comparison, so a change must last at least one system clock to be seen. The direction of a port, input or output, does not matter to the comparison.

Top module: `port_change_irq`

## Requirements
- R1: After reset `irq_o` and `armed_o` are 0 and the mask is all zeros, so port changes after arming cannot set the interrupt until a mask is written.
- R2: A configuration write (`cfg_wr_i`=1) with `cfg_arm_i`=1 sets `armed_o` to 1 and `irq_o` to 0 one edge later. It stores the synchronized port levels as the new baseline, whatever the block's previous state.
- R3: While armed, a port whose mask bit is 1 and whose level differs from its baseline bit sets `irq_o` on the third rising edge after the changed level is presented at `port_lvl_i`. `armed_o` drops on that same edge.
- R4: Bit i of the mask (1 = watch, 0 = ignore) governs port bit i. Changes on ports whose mask bit is 0 leave `irq_o` at 0 and `armed_o` at 1.
- R5: Once set, `irq_o` stays at 1 when the ports return to the baseline or change again.
- R6: A mask read (`mask_rd_i`) or a mask write (`mask_wr_i`) clears `irq_o` one edge later. A configuration write with the enable bit clear does not clear it.
- R7: After an event, detection stays disarmed. Later port changes do not set `irq_o` until a new arming write is made.
- R8: A configuration write with `cfg_arm_i`=0 clears `armed_o` one edge later and leaves `irq_o` unchanged.
- R9: An arming write while `irq_o` is high clears it and takes a fresh baseline. Ports that stay at their current levels afterwards do not set it again.
- R10: A port change that lasts only one clock cycle on a watched port still sets `irq_o`.
- R11: An arming write takes priority over a detection in the same cycle. A detection takes priority over a mask access in the same cycle, so the event is not lost.
- R12: A mask write takes effect for comparisons from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_lvl_i | input | 7 | Asynchronous port levels being watched |
| mask_wr_i | input | 1 | One-cycle mask register write strobe |
| mask_rd_i | input | 1 | One-cycle mask register read strobe |
| mask_wdata_i | input | 7 | Mask value written when `mask_wr_i` is high (bit i watches port i) |
| cfg_wr_i | input | 1 | One-cycle configuration write strobe |
| cfg_arm_i | input | 1 | Enable bit carried by the configuration write |
| irq_o | output | 1 | Latched interrupt level |
| armed_o | output | 1 | Detection is currently armed |

## Verification
Strobe results (arming, disarming, clearing) are due one edge after the strobe. A port change reaches `irq_o` three edges after it is presented: two synchronizer stages, then the interrupt flop. Each table vector is driven on a falling edge, its strobes are held for one edge, and the outputs are sampled on the falling edge after the fourth rising edge, when every result has settled. Directed tests for latency, one-cycle pulses and same-cycle priority instead sample on the falling edge after each individual rising edge, so the exact edge of each output change is pinned down.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WATCH = 1'b1
  } watch_state_e;

  // Returns 1 when any selected bit differs between live and baseline levels.
  function automatic logic masked_mismatch(input logic [31:0] live,
                                           input logic [31:0] base,
                                           input logic [31:0] sel);
    return |((live ^ base) & sel);
  endfunction

endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/pcd_mask_reg.sv
module pcd_mask_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic         access_o
);

  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o   = mask_q;
  assign access_o = wr_i | rd_i;

endmodule

// File: rtl/pcd_core.sv
module pcd_core
  import pcd_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] mask_i,
  input  logic         cfg_wr_i,
  input  logic         cfg_arm_i,
  input  logic         clr_i,
  output logic         irq_o,
  output logic         armed_o
);

  watch_state_e state_q;
  logic [W-1:0] base_q;
  logic         irq_q;
  logic         hit;
  logic         arm_req;

  assign arm_req = cfg_wr_i & cfg_arm_i;
  assign hit     = (state_q == ST_WATCH) &&
                   masked_mismatch(32'(lvl_i), 32'(base_q), 32'(mask_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      irq_q   <= 1'b0;
    end else if (arm_req) begin
      state_q <= ST_WATCH;
      base_q  <= lvl_i;
      irq_q   <= 1'b0;
    end else begin
      if (cfg_wr_i || hit) state_q <= ST_IDLE;
      if (hit)             irq_q   <= 1'b1;
      else if (clr_i)      irq_q   <= 1'b0;
    end
  end

  assign irq_o   = irq_q;
  assign armed_o = (state_q == ST_WATCH);

  assert_cfg_arm_R2: assert property (@(posedge clk) disable iff (rst)
    arm_req |=> (armed_o && !irq_o));

  assert_event_disarms_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> !armed_o);

  assert_event_needs_arm_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(armed_o));

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_i && !arm_req) |=> irq_o);

  assert_access_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !arm_req && !hit) |=> !irq_o);

  assert_stay_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!armed_o && !arm_req) |=> !armed_o);

  assert_cfg_off_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_i && !cfg_arm_i) |=> (!armed_o && (irq_o == $past(irq_o))));

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int NUM_PORTS   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] port_lvl_i,
  input  logic                 mask_wr_i,
  input  logic                 mask_rd_i,
  input  logic [NUM_PORTS-1:0] mask_wdata_i,
  input  logic                 cfg_wr_i,
  input  logic                 cfg_arm_i,
  output logic                 irq_o,
  output logic                 armed_o
);

  logic [NUM_PORTS-1:0] lvl_sync;
  logic [NUM_PORTS-1:0] mask_q;
  logic                 mask_access;

  pcd_sync #(.W(NUM_PORTS), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (port_lvl_i),
    .q_o (lvl_sync)
  );

  pcd_mask_reg #(.W(NUM_PORTS)) mask_i (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (mask_wr_i),
    .rd_i     (mask_rd_i),
    .wdata_i  (mask_wdata_i),
    .mask_o   (mask_q),
    .access_o (mask_access)
  );

  pcd_core #(.W(NUM_PORTS)) core_i (
    .clk       (clk),
    .rst       (rst),
    .lvl_i     (lvl_sync),
    .mask_i    (mask_q),
    .cfg_wr_i  (cfg_wr_i),
    .cfg_arm_i (cfg_arm_i),
    .clr_i     (mask_access),
    .irq_o     (irq_o),
    .armed_o   (armed_o)
  );

endmodule

// File: tb/port_change_irq_tb.sv
module port_change_irq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] port_lvl = '0;
  logic       mask_wr = 1'b0;
  logic       mask_rd = 1'b0;
  logic [6:0] mask_wdata = '0;
  logic       cfg_wr = 1'b0;
  logic       cfg_arm = 1'b0;
  logic       irq;
  logic       armed;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  port_change_irq dut_i (
    .clk          (clk),
    .rst          (rst),
    .port_lvl_i   (port_lvl),
    .mask_wr_i    (mask_wr),
    .mask_rd_i    (mask_rd),
    .mask_wdata_i (mask_wdata),
    .cfg_wr_i     (cfg_wr),
    .cfg_arm_i    (cfg_arm),
    .irq_o        (irq),
    .armed_o      (armed)
  );

  // [23:20] req, [19] cfg_wr, [18] cfg_arm, [17] mask_wr, [16] mask_rd,
  // [15:9] mask value, [8:2] port levels, [1] expected irq, [0] expected armed
  localparam int NV = 18;
  localparam logic [23:0] VECS [NV] = '{
    {4'd12, 4'b0010, 7'h7F, 7'h00, 2'b00},  // R12 mask all ports
    {4'd2,  4'b1100, 7'h00, 7'h00, 2'b01},  // R2 arm, baseline 0x00
    {4'd3,  4'b0000, 7'h00, 7'h01, 2'b10},  // R3 change on port 0
    {4'd5,  4'b0000, 7'h00, 7'h00, 2'b10},  // R5 back to baseline, still set
    {4'd6,  4'b0001, 7'h00, 7'h00, 2'b00},  // R6 mask read clears
    {4'd7,  4'b0000, 7'h00, 7'h10, 2'b00},  // R7 no event while disarmed
    {4'd2,  4'b1100, 7'h00, 7'h10, 2'b01},  // R2 rearm, baseline 0x10
    {4'd4,  4'b0010, 7'h0F, 7'h30, 2'b01},  // R4 port 5 masked off
    {4'd4,  4'b0000, 7'h00, 7'h70, 2'b01},  // R4 ports 4..6 ignored
    {4'd3,  4'b0000, 7'h00, 7'h72, 2'b10},  // R3 port 1 watched
    {4'd8,  4'b1000, 7'h00, 7'h72, 2'b10},  // R8 disable write keeps irq
    {4'd9,  4'b1100, 7'h00, 7'h72, 2'b01},  // R9 arm while irq high
    {4'd9,  4'b0000, 7'h00, 7'h72, 2'b01},  // R9 fresh baseline holds
    {4'd3,  4'b0000, 7'h00, 7'h73, 2'b10},  // R3 port 0 changes
    {4'd6,  4'b0010, 7'h0F, 7'h73, 2'b00},  // R6 mask write clears
    {4'd2,  4'b1100, 7'h00, 7'h73, 2'b01},  // R2 arm
    {4'd8,  4'b1000, 7'h00, 7'h73, 2'b00},  // R8 disable write disarms
    {4'd8,  4'b0000, 7'h00, 7'h00, 2'b00}   // R8 no detection when off
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_strobes();
    cfg_wr  = 1'b0;
    cfg_arm = 1'b0;
    mask_wr = 1'b0;
    mask_rd = 1'b0;
  endtask

  task automatic check(input string req, input logic exp_irq, input logic exp_armed);
    checks++;
    if (irq !== exp_irq || armed !== exp_armed) begin
      errors++;
      $display("FAIL %s: irq=%b armed=%b, expected irq=%b armed=%b",
               req, irq, armed, exp_irq, exp_armed);
    end
  endtask

  task automatic pulse_cfg(input logic en);
    cfg_wr = 1'b1; cfg_arm = en; step(); idle_strobes();
  endtask

  task automatic pulse_mask_rd();
    mask_rd = 1'b1; step(); idle_strobes();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", 1'b0, 1'b0);

    // R1: mask is zero after reset, so no event after arming
    pulse_cfg(1'b1);
    port_lvl = 7'h7F;
    repeat (4) step();
    check("R1 zero mask", 1'b0, 1'b1);
    pulse_cfg(1'b0);
    port_lvl = 7'h00;
    repeat (4) step();

    for (int v = 0; v < NV; v++) begin
      cfg_wr     = VECS[v][19];
      cfg_arm    = VECS[v][18];
      mask_wr    = VECS[v][17];
      mask_rd    = VECS[v][16];
      mask_wdata = VECS[v][15:9];
      port_lvl   = VECS[v][8:2];
      step();
      idle_strobes();
      repeat (3) step();
      checks++;
      if (irq !== VECS[v][1] || armed !== VECS[v][0]) begin
        errors++;
        $display("FAIL R%0d vector %0d: irq=%b armed=%b, expected irq=%b armed=%b",
                 VECS[v][23:20], v, irq, armed, VECS[v][1], VECS[v][0]);
      end
    end

    // Mask is now 0x0F, ports 0x00, disarmed.
    // R3 exact latency
    pulse_cfg(1'b1);
    repeat (3) step();
    port_lvl = 7'h04;
    step(); check("R3 edge 1", 1'b0, 1'b1);
    step(); check("R3 edge 2", 1'b0, 1'b1);
    step(); check("R3 edge 3", 1'b1, 1'b0);

    // R10 one-cycle pulse
    port_lvl = 7'h00;
    repeat (3) step();
    pulse_mask_rd();
    pulse_cfg(1'b1);
    repeat (3) step();
    port_lvl = 7'h02;
    step();
    port_lvl = 7'h00;
    repeat (4) step();
    check("R10 short pulse", 1'b1, 1'b0);

    // R11 detection beats mask access in the same cycle
    pulse_mask_rd();
    pulse_cfg(1'b1);
    repeat (3) step();
    port_lvl = 7'h01;
    step(); step();
    mask_rd = 1'b1;
    step();
    idle_strobes();
    check("R11 event over clear", 1'b1, 1'b0);

    // R11 arming beats detection in the same cycle
    pulse_mask_rd();
    pulse_cfg(1'b1);
    repeat (3) step();
    port_lvl = 7'h00;
    step(); step();
    cfg_wr = 1'b1; cfg_arm = 1'b1;
    step();
    idle_strobes();
    check("R11 arm over event", 1'b0, 1'b1);
    repeat (3) step();
    check("R11 new baseline", 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule